// File: doc/BRIEF.md
# Auto-Incrementing User-Bit Buffer Reader

This block holds the user bits of one received audio block and lets a host fetch them through a narrow two-register window. User bits arrive one at a time on a strobe and are packed into a capture buffer. A block-complete pulse copies the whole capture buffer into a second buffer in a single cycle. The host reads only this second buffer, so a block that is still arriving cannot tear the data the host sees.

The host picks a starting byte by writing the index register. It then reads the data register again and again. Each data read returns the byte at the current index and then moves the index on by one, wrapping at the end of the buffer. One index write followed by a burst of data reads therefore streams out the whole buffer. Write and read channels are separate, so an index write and a data read can land in the same cycle.

Top module: `ub_indirect_reader`

## Requirements
- R1: After reset the index is 0, `rd_data_o` is 0 and every byte of the readable buffer is 0.
- R2: The k-th user bit strobed in a block (k from 0) lands in byte k/8 at bit position k%8, with the least significant bit first. It becomes readable after the block-complete pulse.
- R3: The readable buffer changes only on the cycle of a block-complete pulse. Bits that arrive between pulses do not alter data reads.
- R4: User bits beyond the 192nd in a block are discarded.
- R5: A write to address 0x50 sets the index to the written value. A value of 24 or more sets it to 23.
- R6: A read of address 0x51 puts the byte at the effective index on `rd_data_o` on the clock edge that accepts the read.
- R7: Each read of 0x51 advances the index by one. After a read at 23 the index becomes 0.
- R8: A read of 0x50 returns the index register's value as it was before that cycle's update, zero-extended. It includes all earlier auto-increments.
- R9: When a write to 0x50 and a read of 0x51 happen in the same cycle, the read uses the newly written (clamped) index, and the index afterwards is that value plus one.
- R10: A read of any other address returns 0 and leaves the index unchanged. Writes to any address other than 0x50 are ignored.
- R11: A user-bit strobe in the same cycle as a block-complete pulse is kept as bit 0 of the next block. It is not part of the block being copied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ub_vld_i | input | 1 | User-bit strobe |
| ub_bit_i | input | 1 | User-bit value |
| blk_done_i | input | 1 | Block-complete pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 8 | Register read address |
| rd_data_o | output | 8 | Read data, registered, valid the cycle after the read |

## Verification
The hardest case to reach from the ports is the same-cycle collision of an index write with a data read, together with the wrap of the index at the end of the buffer. The stimulus drives both channels in one cycle with an in-range offset. It then does the same with an out-of-range offset, which clamps to the last byte, so the follow-up read must wrap to 0. Tearing protection is tested by streaming half of a new block, reading bytes of the old block mid-stream, and then finishing with an overlong block. That final block ends on a pulse that coincides with a strobe. The bench then checks both the discarded tail and the carried-over first bit of the following block.

// File: rtl/ub_reader_pkg.sv
package ub_reader_pkg;
  localparam int unsigned NBYTES    = 24;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned ADDR_W    = 8;
  localparam logic [7:0]  IDX_ADDR  = 8'h50;
  localparam logic [7:0]  DATA_ADDR = 8'h51;
endpackage

// File: rtl/ub_capture_buf.sv
module ub_capture_buf #(
  parameter int unsigned NBYTES = 24,
  parameter int unsigned BYTE_W = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         ub_vld_i,
  input  logic                         ub_bit_i,
  input  logic                         blk_done_i,
  output logic [NBYTES-1:0][BYTE_W-1:0] cap_o
);
  localparam int unsigned NBITS = NBYTES * BYTE_W;
  localparam int unsigned CW    = $clog2(NBITS + 1);

  logic [CW-1:0]  cnt_q;
  logic [NBITS-1:0] bits_q;
  logic [CW-1:0]  wr_idx;
  logic           wr_ok;

  // strobe coinciding with block end starts the next block
  assign wr_idx = blk_done_i ? '0 : cnt_q;
  assign wr_ok  = ub_vld_i && (blk_done_i || (cnt_q < CW'(NBITS)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bits_q <= '0;
    end else begin
      if (wr_ok) bits_q[wr_idx] <= ub_bit_i;
      if (blk_done_i)    cnt_q <= ub_vld_i ? CW'(1) : '0;
      else if (wr_ok)    cnt_q <= cnt_q + CW'(1);
    end
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_pack
    assign cap_o[b] = bits_q[b*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/ub_shadow_buf.sv
module ub_shadow_buf #(
  parameter int unsigned NBYTES = 24,
  parameter int unsigned BYTE_W = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          load_i,
  input  logic [NBYTES-1:0][BYTE_W-1:0] cap_i,
  output logic [NBYTES-1:0][BYTE_W-1:0] shd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     shd_o <= '0;
    else if (load_i) shd_o <= cap_i;
  end
endmodule

// File: rtl/ub_offset_ctl.sv
module ub_offset_ctl #(
  parameter int unsigned NBYTES = 24,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned OW    = $clog2(NBYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic [BYTE_W-1:0] set_val_i,
  input  logic              adv_i,
  output logic [OW-1:0]     off_o,
  output logic [OW-1:0]     eff_o
);
  localparam logic [OW-1:0] LAST = OW'(NBYTES - 1);

  logic [OW-1:0] clamped;
  logic [OW-1:0] nxt;

  assign clamped = (set_val_i >= BYTE_W'(NBYTES)) ? LAST : set_val_i[OW-1:0];
  assign eff_o   = set_i ? clamped : off_o;
  assign nxt     = adv_i ? ((eff_o == LAST) ? '0 : eff_o + OW'(1)) : eff_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) off_o <= '0;
    else         off_o <= nxt;
  end
endmodule

// File: rtl/ub_indirect_reader.sv
module ub_indirect_reader
  import ub_reader_pkg::*;
#(
  parameter int unsigned N_BYTES  = NBYTES,
  parameter int unsigned B_W      = BYTE_W,
  parameter int unsigned A_W      = ADDR_W,
  parameter logic [A_W-1:0] A_IDX  = A_W'(IDX_ADDR),
  parameter logic [A_W-1:0] A_DATA = A_W'(DATA_ADDR)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ub_vld_i,
  input  logic           ub_bit_i,
  input  logic           blk_done_i,
  input  logic           wr_en_i,
  input  logic [A_W-1:0] wr_addr_i,
  input  logic [B_W-1:0] wr_data_i,
  input  logic           rd_en_i,
  input  logic [A_W-1:0] rd_addr_i,
  output logic [B_W-1:0] rd_data_o
);
  localparam int unsigned OW = $clog2(N_BYTES);

  logic [N_BYTES-1:0][B_W-1:0] cap;
  logic [N_BYTES-1:0][B_W-1:0] shadow_q;
  logic [OW-1:0]               offset_q;
  logic [OW-1:0]               eff_off;
  logic                        set_idx, rd_data_sel, rd_idx_sel;
  logic [B_W-1:0]              rd_d;

  assign set_idx     = wr_en_i && (wr_addr_i == A_IDX);
  assign rd_data_sel = rd_en_i && (rd_addr_i == A_DATA);
  assign rd_idx_sel  = rd_en_i && (rd_addr_i == A_IDX);

  ub_capture_buf #(.NBYTES(N_BYTES), .BYTE_W(B_W)) u_cap (
    .clk_i, .rst_ni, .ub_vld_i, .ub_bit_i, .blk_done_i, .cap_o(cap)
  );

  ub_shadow_buf #(.NBYTES(N_BYTES), .BYTE_W(B_W)) u_shd (
    .clk_i, .rst_ni, .load_i(blk_done_i), .cap_i(cap), .shd_o(shadow_q)
  );

  ub_offset_ctl #(.NBYTES(N_BYTES), .BYTE_W(B_W)) u_off (
    .clk_i, .rst_ni, .set_i(set_idx), .set_val_i(wr_data_i),
    .adv_i(rd_data_sel), .off_o(offset_q), .eff_o(eff_off)
  );

  always_comb begin
    rd_d = '0;
    if (rd_data_sel)     rd_d = shadow_q[eff_off];
    else if (rd_idx_sel) rd_d = B_W'(offset_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_data_o <= '0;
    else         rd_data_o <= rd_d;
  end
endmodule

// File: rtl/ub_indirect_reader_chk.sv
module ub_indirect_reader_chk #(
  parameter int unsigned N_BYTES = 24,
  parameter int unsigned B_W     = 8,
  parameter int unsigned A_W     = 8,
  parameter logic [A_W-1:0] A_IDX  = 8'h50,
  parameter logic [A_W-1:0] A_DATA = 8'h51,
  localparam int unsigned OW = $clog2(N_BYTES)
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        blk_done_i,
  input logic                        wr_en_i,
  input logic [A_W-1:0]              wr_addr_i,
  input logic [B_W-1:0]              wr_data_i,
  input logic                        rd_en_i,
  input logic [A_W-1:0]              rd_addr_i,
  input logic [B_W-1:0]              rd_data_o,
  input logic [OW-1:0]               offset_q,
  input logic [N_BYTES-1:0][B_W-1:0] shadow_q
);
  logic wr_idx, rd_dat, rd_oth;
  logic [OW-1:0] lim;
  assign wr_idx = wr_en_i && wr_addr_i == A_IDX;
  assign rd_dat = rd_en_i && rd_addr_i == A_DATA;
  assign rd_oth = rd_en_i && rd_addr_i != A_DATA && rd_addr_i != A_IDX;
  assign lim    = (wr_data_i >= B_W'(N_BYTES)) ? OW'(N_BYTES - 1) : wr_data_i[OW-1:0];

  a_r7_offset_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    offset_q < OW'(N_BYTES));

  a_r5_write_clamp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_idx && !rd_dat) |=> offset_q == $past(lim));

  a_r7_post_incr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_dat && !wr_idx) |=>
      offset_q == (($past(offset_q) == OW'(N_BYTES - 1)) ? '0 : $past(offset_q) + OW'(1)));

  a_r9_set_and_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_dat && wr_idx) |=>
      offset_q == (($past(lim) == OW'(N_BYTES - 1)) ? '0 : $past(lim) + OW'(1)));

  a_r6_read_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_dat && !wr_idx) |=> rd_data_o == $past(shadow_q[offset_q]));

  a_r3_shadow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blk_done_i |=> $stable(shadow_q));

  a_r10_other_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_oth && !wr_idx) |=> (rd_data_o == '0) && $stable(offset_q));
endmodule

bind ub_indirect_reader ub_indirect_reader_chk #(
  .N_BYTES(N_BYTES), .B_W(B_W), .A_W(A_W), .A_IDX(A_IDX), .A_DATA(A_DATA)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .blk_done_i(blk_done_i),
  .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
  .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
  .offset_q(offset_q), .shadow_q(shadow_q)
);

// File: tb/ub_indirect_reader_tb_top.sv
`timescale 1ns/1ps
module ub_indirect_reader_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ub_vld = 1'b0, ub_bit = 1'b0, blk_done = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0, rd_data;

  int errors = 0, checks = 0;
  bit finished = 0;
  logic [7:0] mdl [24];
  int moff = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic chk_q = 1'b0;

  always #2 clk = ~clk;

  ub_indirect_reader dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ub_vld_i(ub_vld), .ub_bit_i(ub_bit),
    .blk_done_i(blk_done), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  function automatic logic [7:0] gen(int seed, int i);
    return 8'((i * 29 + seed * 71) ^ (seed * 13 + 8'h5A));
  endfunction

  function automatic logic genbit(int seed, int k);
    if (k >= 192) return 1'b1;
    return gen(seed, k / 8)[k % 8];
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  always @(posedge clk) chk_q <= rd_en && rst_n;

  // monitor
  always @(negedge clk) begin
    if (chk_q && exp_q.size() > 0) check(tag_q.pop_front(), rd_data, exp_q.pop_front());
  end

  task automatic push(logic [7:0] e, string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic do_read(logic [7:0] a, string tag);
    if (a == 8'h51) begin
      push(mdl[moff], tag);
      moff = (moff == 23) ? 0 : moff + 1;
    end else if (a == 8'h50) push(8'(moff), tag);
    else push(8'h00, tag);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_write(logic [7:0] a, logic [7:0] v);
    if (a == 8'h50) moff = (v >= 24) ? 23 : int'(v);
    wr_en = 1'b1; wr_addr = a; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_rd(logic [7:0] v, string tag);
    moff = (v >= 24) ? 23 : int'(v);
    push(mdl[moff], tag);
    moff = (moff == 23) ? 0 : moff + 1;
    wr_en = 1'b1; wr_addr = 8'h50; wr_data = v;
    rd_en = 1'b1; rd_addr = 8'h51;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic feed(int seed, int from, int upto);
    for (int k = from; k < upto; k++) begin
      ub_vld = 1'b1; ub_bit = genbit(seed, k);
      @(negedge clk);
    end
    ub_vld = 1'b0;
  endtask

  task automatic finish_blk(int seed, logic with_bit, logic b);
    for (int i = 0; i < 24; i++) mdl[i] = gen(seed, i);
    blk_done = 1'b1; ub_vld = with_bit; ub_bit = b;
    @(negedge clk);
    blk_done = 1'b0; ub_vld = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 24; i++) mdl[i] = 8'h00;
    repeat (3) @(negedge clk);
    check("R1", rd_data, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    do_read(8'h50, "R1");
    do_read(8'h51, "R1");
    do_read(8'h50, "R8");
    // block A arrives; nothing visible before the pulse
    feed(1, 0, 192);
    do_write(8'h50, 8'd2);
    do_read(8'h51, "R3");
    finish_blk(1, 1'b0, 1'b0);
    do_write(8'h50, 8'd0);
    for (int i = 0; i < 24; i++) do_read(8'h51, "R2");
    do_read(8'h50, "R7");
    // clamp and wrap
    do_write(8'h50, 8'd30);
    do_read(8'h50, "R5");
    do_read(8'h51, "R5");
    do_read(8'h50, "R7");
    do_write(8'h50, 8'd24);
    do_read(8'h50, "R5");
    // collision of index write and data read
    wr_rd(8'd10, "R9");
    do_read(8'h50, "R9");
    wr_rd(8'd99, "R9");
    do_read(8'h50, "R9");
    // other addresses
    do_write(8'h50, 8'd5);
    do_write(8'h51, 8'd17);
    do_read(8'h40, "R10");
    do_read(8'h50, "R10");
    // block B streams in while host reads block A
    feed(2, 0, 100);
    do_read(8'h51, "R3");
    do_read(8'h51, "R3");
    feed(2, 100, 200);
    do_read(8'h51, "R4");
    finish_blk(2, 1'b1, 1'b1);
    do_write(8'h50, 8'd0);
    for (int i = 0; i < 24; i++) do_read(8'h51, "R4");
    // block C: bit 0 came with the previous pulse
    feed(3, 1, 192);
    finish_blk(3, 1'b0, 1'b0);
    mdl[0][0] = 1'b1;
    do_write(8'h50, 8'd0);
    do_read(8'h51, "R11");
    do_read(8'h51, "R2");
    do_write(8'h50, 8'd23);
    do_read(8'h51, "R6");
    do_read(8'h51, "R7");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R6 actual=%0d pending expected=0", exp_q.size());
    end
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule